// File: doc/BRIEF.md
# Bayer Video Timing Generator

This block produces the parallel output stream of a progressive-scan colour image sensor. On every rising edge of its clock it updates a 12-bit pixel word, a frame-valid strobe and a line-valid strobe. A downstream receiver captures all three on the falling edge. The pixel values are synthetic test-pattern content in Bayer colour order. A capture block connected to this output can therefore be checked against data whose every bit is known in advance.

The window width, window height, horizontal blanking and vertical blanking are inputs. They are sampled only at frame boundaries. Each frame begins with its vertical blanking lines, followed by its active lines. Every line, blank or active, is `width + hblank` clocks long. Each pixel's colour phase follows from the parity of its row and column in the full array. The window's origin within that array is a parameter, with a default of column 16, row 54.

Top module: `bayer_vtg`

## Requirements
- R1: The pixel word has 12 bits, MSB at bit 11. During an active pixel, bits [9:0] equal `(array_col + array_row) mod 1024`, where `array_col = 16 + x` and `array_row = 54 + y`, and x/y are the pixel's column and row inside the window, counted from 0.
- R2: During an active pixel, bits [11:10] carry the colour phase `{array_row[0], array_col[0]}`: 0 = Gr, 1 = R, 2 = B, 3 = Gb. The first window row alternates Gr, R, ... starting with Gr. The second row alternates B, Gb, ... starting with B. The pattern repeats every two rows.
- R3: On every active line, line_valid is high for exactly `width` consecutive clocks and then low for `hblank` clocks.
- R4: frame_valid rises together with the first line_valid of a frame. It stays high through the horizontal blanking between that frame's lines. It falls on the clock after the frame's last pixel. line_valid is never high while frame_valid is low.
- R5: Between the end of one frame's last pixel and the start of the next frame, frame_valid stays low for exactly `hblank + vblank*(width+hblank)` clocks. Each frame contains exactly `height` active lines.
- R6: The pixel word is zero whenever line_valid is low.
- R7: The four configuration inputs are sampled only during reset and on the first clock of vertical blanking. A change made while a frame is being output has no effect on that frame and takes effect in the next one.
- R8: A configuration input of zero is treated as one.
- R9: A synchronous active-high reset drives all three outputs low on the next clock and restarts the sequence at the start of vertical blanking. The first line_valid after reset is released appears on the `vblank*(width+hblank)+1`-th clock.
- R10: The outputs change only just after a rising clock edge and are stable over the whole low phase of the clock, which is the falling-edge capture window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; outputs update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | 12 | Active pixels per line |
| cfg_height | input | 12 | Active lines per frame |
| cfg_hblank | input | 12 | Blanking clocks at the end of each line |
| cfg_vblank | input | 12 | Blank lines at the start of each frame |
| frame_valid | output | 1 | High across a frame's active lines and the blanking between them |
| line_valid | output | 1 | High during active pixels |
| pixel | output | 12 | Bayer test-pattern word, zero during blanking |

## Verification
The following properties are checked on every clock:
- line_valid is contained within frame_valid.
- The pixel word is zero outside line_valid.
- The column-parity bit toggles, and the row-parity bit holds, between neighbouring pixels of a line.
- Every line_valid pulse lasts exactly the configured width.
- The sampled configuration never moves while frame_valid is high.
- The outputs are quiet after reset.

Other behaviours depend on a sequence of scenarios and can only be shown by the bench's scenarios:
- The gap length between frames.
- The line count per frame.
- Deferred loading of a configuration changed mid-frame.
- Zero clamping.
- The delay to the first line after reset.

These are checked against a behavioural reference model that predicts every output word.

// File: rtl/bayer_vtg_pkg.sv
package bayer_vtg_pkg;

    localparam int PIX_W = 12;
    localparam int DIM_W = 12;
    localparam int CNT_W = DIM_W + 1;

    typedef logic [DIM_W-1:0] dim_t;
    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [PIX_W-1:0] pix_t;

    typedef struct packed {
        dim_t width;
        dim_t height;
        dim_t hblank;
        dim_t vblank;
    } vtg_cfg_t;

    typedef enum logic [1:0] {
        PH_GR = 2'd0,
        PH_R  = 2'd1,
        PH_B  = 2'd2,
        PH_GB = 2'd3
    } bayer_ph_e;

    typedef struct packed {
        logic fv;
        logic lv;
        pix_t data;
    } vtg_out_t;

    typedef struct packed {
        logic row_on;
        logic pix_on;
        logic last_row;
        dim_t x;
        dim_t y;
    } scan_pos_t;

    function automatic dim_t at_least_one(dim_t v);
        return (v == '0) ? dim_t'(1) : v;
    endfunction

    function automatic bayer_ph_e phase_of(logic row_odd, logic col_odd);
        return bayer_ph_e'({row_odd, col_odd});
    endfunction

endpackage

// File: rtl/vtg_cfg_hold.sv
module vtg_cfg_hold
    import bayer_vtg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load_en,
    input  vtg_cfg_t cfg_in,
    output vtg_cfg_t cfg_q
);

    vtg_cfg_t clamped;

    always_comb begin
        clamped.width  = at_least_one(cfg_in.width);
        clamped.height = at_least_one(cfg_in.height);
        clamped.hblank = at_least_one(cfg_in.hblank);
        clamped.vblank = at_least_one(cfg_in.vblank);
    end

    always_ff @(posedge clk) begin
        if (rst || load_en) begin
            cfg_q <= clamped;
        end
    end

endmodule

// File: rtl/vtg_scan.sv
module vtg_scan
    import bayer_vtg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  vtg_cfg_t  cfg,
    output logic      frame_start,
    output scan_pos_t pos
);

    cnt_t hcnt;
    cnt_t vcnt;
    cnt_t line_len;
    cnt_t frame_lines;
    cnt_t row_idx;

    assign line_len    = CNT_W'(cfg.width) + CNT_W'(cfg.hblank);
    assign frame_lines = CNT_W'(cfg.vblank) + CNT_W'(cfg.height);

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (hcnt >= line_len - CNT_W'(1)) begin
            hcnt <= '0;
            vcnt <= (vcnt >= frame_lines - CNT_W'(1)) ? '0 : vcnt + CNT_W'(1);
        end else begin
            hcnt <= hcnt + CNT_W'(1);
        end
    end

    assign frame_start = (hcnt == '0) && (vcnt == '0);
    assign row_idx     = vcnt - CNT_W'(cfg.vblank);

    always_comb begin
        pos.row_on   = (vcnt >= CNT_W'(cfg.vblank));
        pos.pix_on   = pos.row_on && (hcnt < CNT_W'(cfg.width));
        pos.x        = DIM_W'(hcnt);
        pos.y        = DIM_W'(row_idx);
        pos.last_row = (pos.y == cfg.height - dim_t'(1));
    end

endmodule

// File: rtl/vtg_pattern.sv
module vtg_pattern
    import bayer_vtg_pkg::*;
#(
    parameter int unsigned COL_ORIGIN = 16,
    parameter int unsigned ROW_ORIGIN = 54
) (
    input  dim_t x,
    input  dim_t y,
    input  logic pix_on,
    output pix_t data
);

    localparam int MIX_W = PIX_W - 2;

    cnt_t             col;
    cnt_t             row;
    logic [MIX_W-1:0] mix;
    bayer_ph_e        ph;

    always_comb begin
        col  = CNT_W'(x) + CNT_W'(COL_ORIGIN);
        row  = CNT_W'(y) + CNT_W'(ROW_ORIGIN);
        mix  = MIX_W'(col + row);
        ph   = phase_of(row[0], col[0]);
        data = pix_on ? {ph, mix} : '0;
    end

endmodule

// File: rtl/bayer_vtg.sv
module bayer_vtg
    import bayer_vtg_pkg::*;
#(
    parameter int unsigned COL_ORIGIN = 16,
    parameter int unsigned ROW_ORIGIN = 54
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIM_W-1:0] cfg_width,
    input  logic [DIM_W-1:0] cfg_height,
    input  logic [DIM_W-1:0] cfg_hblank,
    input  logic [DIM_W-1:0] cfg_vblank,
    output logic             frame_valid,
    output logic             line_valid,
    output logic [PIX_W-1:0] pixel
);

    vtg_cfg_t  cfg_in;
    vtg_cfg_t  cfg_q;
    logic      frame_start;
    scan_pos_t pos;
    pix_t      pat;
    vtg_out_t  nxt;
    vtg_out_t  out_q;

    assign cfg_in = '{width: cfg_width, height: cfg_height,
                      hblank: cfg_hblank, vblank: cfg_vblank};

    vtg_cfg_hold u_cfg (
        .clk     (clk),
        .rst     (rst),
        .load_en (frame_start),
        .cfg_in  (cfg_in),
        .cfg_q   (cfg_q)
    );

    vtg_scan u_scan (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg_q),
        .frame_start (frame_start),
        .pos         (pos)
    );

    vtg_pattern #(
        .COL_ORIGIN (COL_ORIGIN),
        .ROW_ORIGIN (ROW_ORIGIN)
    ) u_pat (
        .x      (pos.x),
        .y      (pos.y),
        .pix_on (pos.pix_on),
        .data   (pat)
    );

    always_comb begin
        nxt.lv   = pos.pix_on;
        nxt.fv   = pos.row_on && !(pos.last_row && !pos.pix_on);
        nxt.data = pat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= nxt;
        end
    end

    assign frame_valid = out_q.fv;
    assign line_valid  = out_q.lv;
    assign pixel       = out_q.data;

endmodule

// File: rtl/bayer_vtg_chk.sv
module bayer_vtg_chk
    import bayer_vtg_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     fv,
    input logic     lv,
    input pix_t     pix,
    input vtg_cfg_t cfg_q
);

    dim_t run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= '0;
        end else begin
            run <= lv ? run + dim_t'(1) : '0;
        end
    end

    assert_lv_inside_fv_R4: assert property (@(posedge clk) disable iff (rst)
        lv |-> fv);

    assert_blank_zero_R6: assert property (@(posedge clk) disable iff (rst)
        !lv |-> (pix == '0));

    assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
        (lv && $past(lv)) |->
            ((pix[PIX_W-2] != $past(pix[PIX_W-2])) && (pix[PIX_W-1] == $past(pix[PIX_W-1]))));

    assert_line_length_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(lv) && !$past(rst)) |-> ($past(run) == cfg_q.width - dim_t'(1)));

    assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (fv && $past(fv)) |-> $stable(cfg_q));

    assert_reset_quiet_R9: assert property (@(posedge clk)
        rst |=> (!fv && !lv && (pix == '0)));

endmodule

bind bayer_vtg bayer_vtg_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .fv    (frame_valid),
    .lv    (line_valid),
    .pix   (pixel),
    .cfg_q (cfg_q)
);

// File: tb/bayer_vtg_tb.sv
module bayer_vtg_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] cfg_w = 12'd8;
    logic [11:0] cfg_h = 12'd4;
    logic [11:0] cfg_hb = 12'd3;
    logic [11:0] cfg_vb = 12'd2;
    logic        fv;
    logic        lv;
    logic [11:0] pix;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    bayer_vtg u_dut (
        .clk         (clk),
        .rst         (rst),
        .cfg_width   (cfg_w),
        .cfg_height  (cfg_h),
        .cfg_hblank  (cfg_hb),
        .cfg_vblank  (cfg_vb),
        .frame_valid (fv),
        .line_valid  (lv),
        .pixel       (pix)
    );

    function automatic int one(int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // behavioural reference model, advanced on every falling edge
    int mh = 0, mv = 0, cw = 1, ch = 1, chb = 1, cvb = 1;

    always @(negedge clk) begin : model
        logic        efv, elv;
        logic [11:0] ed;
        int          y, col, row;
        logic        sfv, slv;
        logic [11:0] spx;
        bit          at00;
        efv = 0; elv = 0; ed = '0;
        if (rst) begin
            mh = 0; mv = 0;
            cw = one(int'(cfg_w)); ch = one(int'(cfg_h));
            chb = one(int'(cfg_hb)); cvb = one(int'(cfg_vb));
        end else begin
            if (mv >= cvb) begin
                y   = mv - cvb;
                elv = (mh < cw);
                efv = !((y == ch - 1) && (mh >= cw));
                if (elv) begin
                    col = 16 + mh;
                    row = 54 + y;
                    ed  = 12'((row % 2) * 2048 + (col % 2) * 1024 + ((col + row) % 1024));
                end
            end
            at00 = (mh == 0) && (mv == 0);
            mh++;
            if (mh >= cw + chb) begin
                mh = 0;
                mv++;
                if (mv >= cvb + ch) mv = 0;
            end
            if (at00) begin
                cw = one(int'(cfg_w)); ch = one(int'(cfg_h));
                chb = one(int'(cfg_hb)); cvb = one(int'(cfg_vb));
            end
        end
        if (lv !== elv)
            check(0, "R3 line_valid", int'(lv), int'(elv));
        else if (fv !== efv)
            check(0, "R4 frame_valid", int'(fv), int'(efv));
        else if (pix !== ed && !elv)
            check(0, "R6 blank pixel", int'(pix), int'(ed));
        else if (pix[11:10] !== ed[11:10])
            check(0, "R2 colour phase", int'(pix[11:10]), int'(ed[11:10]));
        else
            check(pix === ed, "R1 pixel word", int'(pix), int'(ed));
        sfv = fv; slv = lv; spx = pix;
        #(CLK_P/2 - 2);
        check({fv, lv, pix} === {sfv, slv, spx}, "R10 stable in low phase",
              int'({fv, lv, pix}), int'({sfv, slv, spx}));
    end

    task automatic drive(int w, int h, int hb, int vb);
        cfg_w = 12'(w); cfg_h = 12'(h); cfg_hb = 12'(hb); cfg_vb = 12'(vb);
    endtask

    // skips any frame in progress, then measures the next one and the gap after it
    task automatic measure_frame(int ew, int eh, int egap, string req);
        int  w = 0, lines = 0, gap = 0;
        bit  plv = 0;
        @(negedge clk);
        while (fv) @(negedge clk);
        while (!fv) @(negedge clk);
        while (fv) begin
            if (lv && !plv) lines++;
            if (lv && lines == 1) w++;
            plv = lv;
            @(negedge clk);
        end
        while (!fv) begin
            gap++;
            @(negedge clk);
        end
        check(w == ew, {req, " line width"}, w, ew);
        check(lines == eh, {req, " lines per frame"}, lines, eh);
        check(gap == egap, {req, " frame gap"}, gap, egap);
    endtask

    task automatic first_line_delay(int exp, string req);
        int n = 0;
        @(negedge clk); #1 rst = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!lv && n < 5000);
        check(n == exp, req, n, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: outputs quiet while reset is held
        check(!fv && !lv && pix == 0, "R9 reset outputs", int'({fv, lv, pix}), 0);
        first_line_delay(2 * 11 + 1, "R9 first line after reset");
        measure_frame(8, 4, 3 + 2 * 11, "R5");

        // R7: change mid-frame, current frame keeps its width
        while (!fv) @(negedge clk);
        #1 drive(5, 3, 2, 1);
        begin
            int w = 0;
            while (lv) @(negedge clk);
            while (!lv) @(negedge clk);
            while (lv) begin w++; @(negedge clk); end
            check(w == 8, "R7 frame in progress unchanged", w, 8);
        end
        measure_frame(5, 3, 2 + 7, "R7");

        // R8: zero inputs behave as one
        #1 drive(0, 0, 0, 0);
        measure_frame(1, 1, 1 + 2, "R8");

        // larger frame
        #1 drive(20, 6, 4, 3);
        measure_frame(20, 6, 4 + 3 * 24, "R5");

        // R9: reset in the middle of an active line
        while (!lv) @(negedge clk);
        @(negedge clk);
        #1 rst = 1;
        @(negedge clk);
        check(!fv && !lv && pix == 0, "R9 mid-line reset", int'({fv, lv, pix}), 0);
        @(negedge clk);
        first_line_delay(3 * 24 + 1, "R9 restart delay");
        repeat (40) @(negedge clk);
        report();
    end

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL R5 watchdog actual=timeout expected=completion");
        report();
    end

endmodule